// File: doc/BRIEF.md
# Display Panel Power-State Sequencer

This block steps a display panel's controller between four power states: deep standby, sleep, full-resolution normal and quarter-resolution normal. The panel is reached only through a command writer that sits behind a simple request/done handshake. A caller asks for a target state. The block works out the chain of intermediate states the panel needs, then plays the fixed command script of each hop in turn. It inserts one-millisecond pauses where the wake-up script calls for them, and finishes a trip into either normal state with a display-on command.

The current state is committed only when every command in the chain has been acknowledged without error. A writer error stops the chain at once, raises an error flag and leaves the state as it was. The pause length comes from a clock-rate parameter in kilohertz. The panel-timing initialisation that follows each entry into a normal state is a short parameterised list of register/byte pairs, followed by one resolution-specific horizontal-clock word.

Outbound commands use a valid/done pairing. Once `cmd_valid` rises, address, length and data hold steady until `wr_done` is seen, and at least one idle cycle follows every completion. The writer applies back-pressure simply by delaying `wr_done`. Requests are taken only while `req_ready` is high, and a request presented while a sequence runs is dropped.

Top module: `panel_pwr_seq`

## Requirements
- R1: After reset, `cur_state` is 0 (deep standby), and `busy`, `cmd_valid`, `seq_ok` and `seq_err` are low while `req_ready` is high. States are encoded as 0 deep standby, 1 sleep, 2 normal and 3 quarter normal.
- R2: The hop from deep standby to sleep sends three commands to address 0x00 with length 0. The next command starts no earlier than CLK_KHZ cycles after the `wr_done` of each of those three. The hop ends with a write of 0x17 to 0xB0 with length 1.
- R3: The hop from sleep to normal sends the following, in order:
  - 0x80→0xBC, 0x00→0x3B and 0x16→0xB0, each with length 1.
  - 0xFFF9→0xB8 with length 2.
  - 0x11 with length 0.
  - The initialisation list, which by default is 0x01→0xBA, 0x00→0xBB, 0x60→0x3A and 0x10→0xBF, each with length 1.
  - 0x01F0→0xEC with length 2.
- R4: The hop from sleep to quarter normal has the same shape as R3, with three differences: 0x81→0xBC, 0x22→0x3B, and 0x00FF→0xED in place of the 0xEC write.
- R5: The hop from either normal state to sleep sends 0x28 with length 0, then 0x8002→0xB8 with length 2, then 0x10 with length 0.
- R6: The hop from sleep to deep standby sends 0x00→0xB0 with length 1.
- R7: Requests are routed through intermediate states:
  - Deep standby to a normal state goes through sleep.
  - A normal state to deep standby goes through sleep.
  - One normal state to the other goes through sleep, then deep standby, then sleep.
  - Every chain ending in a normal state adds a final display-on command, 0x29 with length 0.
- R8: A request for the state already held issues no command. `seq_ok` pulses in the cycle after acceptance.
- R9: `cur_state` changes only in the cycle where `seq_ok` pulses, and then to the requested state.
- R10: A completion with `wr_err` high aborts the chain, so no further command is issued. `seq_err` goes high and `cur_state` keeps its old value. `seq_err` clears when the next request is accepted.
- R11: While a sequence runs, `req_ready` is low and requests have no effect on the commands issued or on the final state.
- R12: Once raised, `cmd_valid` stays high with stable address, length and data until `wr_done`, and it is low in the cycle after `wr_done`. Length codes are 0 for no data, 1 for one byte in `cmd_data[7:0]` and 2 for two bytes, high byte sent first. Unused data bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Target-state request strobe |
| req_state | input | 2 | Requested state |
| req_ready | output | 1 | High when a request can be accepted |
| cmd_valid | output | 1 | Command pending to the writer |
| cmd_addr | output | 8 | Command / register address |
| cmd_len | output | 2 | Data byte count (0, 1 or 2) |
| cmd_data | output | 16 | Data value, right-aligned |
| wr_done | input | 1 | Writer completion pulse |
| wr_err | input | 1 | Writer error, valid with wr_done |
| cur_state | output | 2 | Committed power state |
| busy | output | 1 | Sequence in progress |
| seq_ok | output | 1 | One-cycle success pulse |
| seq_err | output | 1 | Last sequence aborted on error |

## Verification
The main function is driven through a walk of thirteen targets that covers every ordered pair of states, plus one repeat of the held state. The full command transcript of each step is compared against one built independently from the hop scripts. Single-hop pairs pin down each hop's script on its own, the deep-standby-to-normal pairs show the hop through sleep, and the normal-to-normal swaps show the four-hop detour together with the display-on tail. Directed cases then show three further behaviours: the pause spacing of the wake commands, an error injected mid-chain (which stops the commands and keeps the state), and requests presented during a run (which leave the transcript and the final state untouched).

// File: rtl/panel_seq_pkg.sv
package panel_seq_pkg;

  typedef enum logic [1:0] {
    PS_STANDBY = 2'd0,
    PS_SLEEP   = 2'd1,
    PS_NORMAL  = 2'd2,
    PS_QUARTER = 2'd3
  } pstate_t;

  typedef enum logic [2:0] {
    SG_WAKE  = 3'd0,
    SG_DEEP  = 3'd1,
    SG_QUIET = 3'd2,
    SG_FULL  = 3'd3,
    SG_QTR   = 3'd4,
    SG_SHOW  = 3'd5
  } seg_t;

  typedef struct packed {
    logic [7:0]  addr;
    logic [1:0]  len;
    logic [15:0] data;
    logic        pause;
    logic        tail;
  } step_t;

  localparam int MAX_SEGS = 5;
  localparam int SEG_W    = 3;

endpackage

// File: rtl/panel_seq_timer.sv
module panel_seq_timer #(
  parameter int unsigned TICKS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expired
);
  localparam int CW = (TICKS < 2) ? 1 : $clog2(TICKS + 1);

  logic [CW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (start) begin
      cnt <= CW'(TICKS - 1);
      run <= 1'b1;
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end

  assign expired = run && (cnt == '0);

  // R2: a new pause is never requested while one is still counting
  a_r2_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !run);

endmodule

// File: rtl/panel_seq_route.sv
module panel_seq_route
  import panel_seq_pkg::*;
(
  input  logic [1:0]                    from_i,
  input  logic [1:0]                    to_i,
  output logic [MAX_SEGS-1:0][SEG_W-1:0] plan_o,
  output logic [2:0]                    count_o
);
  pstate_t src, dst;
  seg_t    rise;

  always_comb begin
    src  = pstate_t'(from_i);
    dst  = pstate_t'(to_i);
    rise = (dst == PS_QUARTER) ? SG_QTR : SG_FULL;
    for (int i = 0; i < MAX_SEGS; i++) plan_o[i] = SG_SHOW;
    count_o = 3'd0;
    unique case (src)
      PS_STANDBY: begin
        plan_o[0] = SG_WAKE;
        if (dst == PS_SLEEP) count_o = 3'd1;
        else if (dst != PS_STANDBY) begin
          plan_o[1] = rise;
          plan_o[2] = SG_SHOW;
          count_o   = 3'd3;
        end
      end
      PS_SLEEP: begin
        if (dst == PS_STANDBY) begin
          plan_o[0] = SG_DEEP;
          count_o   = 3'd1;
        end else if (dst != PS_SLEEP) begin
          plan_o[0] = rise;
          plan_o[1] = SG_SHOW;
          count_o   = 3'd2;
        end
      end
      default: begin
        plan_o[0] = SG_QUIET;
        if (dst == PS_SLEEP) count_o = 3'd1;
        else if (dst == PS_STANDBY) begin
          plan_o[1] = SG_DEEP;
          count_o   = 3'd2;
        end else if (dst != src) begin
          plan_o[1] = SG_DEEP;
          plan_o[2] = SG_WAKE;
          plan_o[3] = rise;
          plan_o[4] = SG_SHOW;
          count_o   = 3'd5;
        end
      end
    endcase
  end

endmodule

// File: rtl/panel_seq_script.sv
module panel_seq_script
  import panel_seq_pkg::*;
#(
  parameter int unsigned INIT_N    = 4,
  parameter logic [INIT_N*16-1:0] INIT_LIST = 64'hBA01_BB00_3A60_BF10,
  parameter int unsigned IDX_W     = 4
) (
  input  seg_t             seg,
  input  logic [IDX_W-1:0] idx,
  output step_t            st
);
  localparam int FIXED_HEAD = 5;

  int  k;
  logic q;

  always_comb begin
    st = '0;
    k  = 0;
    q  = (seg == SG_QTR);
    unique case (seg)
      SG_WAKE: begin
        if (int'(idx) < 3) begin
          st.addr  = 8'h00;
          st.pause = 1'b1;
        end else begin
          st.addr = 8'hB0; st.len = 2'd1; st.data = 16'h0017; st.tail = 1'b1;
        end
      end
      SG_DEEP: begin
        st.addr = 8'hB0; st.len = 2'd1; st.data = 16'h0000; st.tail = 1'b1;
      end
      SG_QUIET: begin
        if (idx == '0) st.addr = 8'h28;
        else if (int'(idx) == 1) begin
          st.addr = 8'hB8; st.len = 2'd2; st.data = 16'h8002;
        end else begin
          st.addr = 8'h10; st.tail = 1'b1;
        end
      end
      SG_FULL, SG_QTR: begin
        if (idx == '0) begin
          st.addr = 8'hBC; st.len = 2'd1; st.data = q ? 16'h0081 : 16'h0080;
        end else if (int'(idx) == 1) begin
          st.addr = 8'h3B; st.len = 2'd1; st.data = q ? 16'h0022 : 16'h0000;
        end else if (int'(idx) == 2) begin
          st.addr = 8'hB0; st.len = 2'd1; st.data = 16'h0016;
        end else if (int'(idx) == 3) begin
          st.addr = 8'hB8; st.len = 2'd2; st.data = 16'hFFF9;
        end else if (int'(idx) == 4) begin
          st.addr = 8'h11;
        end else if (int'(idx) < FIXED_HEAD + int'(INIT_N)) begin
          k       = int'(idx) - FIXED_HEAD;
          st.addr = INIT_LIST[(int'(INIT_N) - 1 - k) * 16 + 8 +: 8];
          st.len  = 2'd1;
          st.data = {8'h00, INIT_LIST[(int'(INIT_N) - 1 - k) * 16 +: 8]};
        end else begin
          st.addr = q ? 8'hED : 8'hEC;
          st.len  = 2'd2;
          st.data = q ? 16'h00FF : 16'h01F0;
          st.tail = 1'b1;
        end
      end
      default: begin
        st.addr = 8'h29; st.tail = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
  import panel_seq_pkg::*;
#(
  parameter int unsigned CLK_KHZ   = 250000,
  parameter int unsigned INIT_N    = 4,
  parameter logic [INIT_N*16-1:0] INIT_LIST = 64'hBA01_BB00_3A60_BF10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [1:0]  req_state,
  output logic        req_ready,
  output logic        cmd_valid,
  output logic [7:0]  cmd_addr,
  output logic [1:0]  cmd_len,
  output logic [15:0] cmd_data,
  input  logic        wr_done,
  input  logic        wr_err,
  output logic [1:0]  cur_state,
  output logic        busy,
  output logic        seq_ok,
  output logic        seq_err
);
  localparam int unsigned SCRIPT_LEN = 6 + INIT_N;
  localparam int IDX_W = $clog2(SCRIPT_LEN);
  localparam int POS_W = $clog2(MAX_SEGS);

  typedef enum logic [1:0] {PH_IDLE, PH_ISSUE, PH_PAUSE, PH_STEP} phase_t;

  phase_t                         phase;
  logic [MAX_SEGS-1:0][SEG_W-1:0] plan_q;
  logic [2:0]                     nseg_q;
  logic [POS_W-1:0]               segpos;
  logic [IDX_W-1:0]               idx;
  logic [1:0]                     target_q;
  logic [1:0]                     cur_q;
  logic                           ok_q, err_q;

  logic [MAX_SEGS-1:0][SEG_W-1:0] route_plan;
  logic [2:0]                     route_n;
  seg_t                           cur_seg;
  step_t                          step;
  logic                           tmr_start, tmr_expired;
  logic                           last_seg;

  panel_seq_route u_route (
    .from_i  (cur_q),
    .to_i    (req_state),
    .plan_o  (route_plan),
    .count_o (route_n)
  );

  assign cur_seg = seg_t'(plan_q[segpos]);

  panel_seq_script #(
    .INIT_N    (INIT_N),
    .INIT_LIST (INIT_LIST),
    .IDX_W     (IDX_W)
  ) u_script (
    .seg (cur_seg),
    .idx (idx),
    .st  (step)
  );

  assign tmr_start = (phase == PH_ISSUE) && wr_done && !wr_err && step.pause;

  panel_seq_timer #(.TICKS(CLK_KHZ)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (tmr_start),
    .expired (tmr_expired)
  );

  assign last_seg = ({{(3-POS_W){1'b0}}, segpos} == nseg_q - 3'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      nseg_q   <= '0;
      segpos   <= '0;
      idx      <= '0;
      target_q <= PS_STANDBY;
      cur_q    <= PS_STANDBY;
      ok_q     <= 1'b0;
      err_q    <= 1'b0;
      for (int i = 0; i < MAX_SEGS; i++) plan_q[i] <= SG_SHOW;
    end else begin
      ok_q <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (req_valid) begin
            err_q <= 1'b0;
            if (req_state == cur_q) ok_q <= 1'b1;
            else begin
              plan_q   <= route_plan;
              nseg_q   <= route_n;
              target_q <= req_state;
              segpos   <= '0;
              idx      <= '0;
              phase    <= PH_ISSUE;
            end
          end
        end
        PH_ISSUE: begin
          if (wr_done) begin
            if (wr_err) begin
              err_q <= 1'b1;
              phase <= PH_IDLE;
            end else if (step.pause) phase <= PH_PAUSE;
            else                     phase <= PH_STEP;
          end
        end
        PH_PAUSE: begin
          if (tmr_expired) phase <= PH_STEP;
        end
        default: begin
          if (step.tail) begin
            if (last_seg) begin
              cur_q <= target_q;
              ok_q  <= 1'b1;
              phase <= PH_IDLE;
            end else begin
              segpos <= segpos + 1'b1;
              idx    <= '0;
              phase  <= PH_ISSUE;
            end
          end else begin
            idx   <= idx + 1'b1;
            phase <= PH_ISSUE;
          end
        end
      endcase
    end
  end

  assign req_ready = (phase == PH_IDLE);
  assign busy      = (phase != PH_IDLE);
  assign cmd_valid = (phase == PH_ISSUE);
  assign cmd_addr  = step.addr;
  assign cmd_len   = step.len;
  assign cmd_data  = step.data;
  assign cur_state = cur_q;
  assign seq_ok    = ok_q;
  assign seq_err   = err_q;

  // R12: command fields hold until the writer completes
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !wr_done |=> cmd_valid && $stable(cmd_addr)
                              && $stable(cmd_len) && $stable(cmd_data));

  // R12: an idle cycle follows every completion
  a_r12_gap: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && wr_done |=> !cmd_valid);

  // R9: the committed state moves only together with the success pulse
  a_r9_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_state) |-> seq_ok);

  // R10: an abort leaves the state alone and stops issuing
  a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_err) |-> $stable(cur_state) && !cmd_valid && !seq_ok);

  // R11: the latched target cannot be disturbed during a run
  a_r11_target: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(target_q));

endmodule

// File: tb/sim_panel_pwr_seq.sv
module sim_panel_pwr_seq;
  localparam int KHZ = 20;
  localparam int NV  = 13;
  // Walk: R2 (0->1), R3 (1->2), R4/R5/R6 in the swaps and returns, R8 at index 3
  localparam logic [1:0] TO_TAB [NV] = '{2'd1, 2'd2, 2'd3, 2'd3, 2'd1, 2'd0, 2'd3,
                                         2'd2, 2'd0, 2'd2, 2'd1, 2'd3, 2'd0};
  localparam int N_TAB [NV] = '{4, 11, 19, 0, 3, 1, 15, 19, 4, 15, 3, 11, 4};

  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [1:0] req_state = 0;
  logic req_ready, cmd_valid, busy, seq_ok, seq_err;
  logic [7:0] cmd_addr;
  logic [1:0] cmd_len, cur_state;
  logic [15:0] cmd_data;
  logic wr_done = 0, wr_err = 0;

  int total = 0, bad = 0, cyc = 0, err_at = 999;
  int act_n = 0, exp_n = 0;
  logic [7:0]  la [64]; logic [1:0] ll [64]; logic [15:0] ld [64]; int lt [64];
  logic [7:0]  ea [64]; logic [1:0] el [64]; logic [15:0] ed [64];

  panel_pwr_seq #(.CLK_KHZ(KHZ)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_state(req_state),
    .req_ready(req_ready), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
    .cmd_len(cmd_len), .cmd_data(cmd_data), .wr_done(wr_done), .wr_err(wr_err),
    .cur_state(cur_state), .busy(busy), .seq_ok(seq_ok), .seq_err(seq_err));

  always #2 clk = ~clk;
  initial forever begin @(posedge clk); cyc++; end

  // writer model: one-cycle latency, optional error on entry err_at
  initial forever begin
    @(posedge clk); #1;
    if (wr_done) begin
      wr_done = 0; wr_err = 0;
    end else if (cmd_valid) begin
      if (act_n < 64) begin
        la[act_n] = cmd_addr; ll[act_n] = cmd_len; ld[act_n] = cmd_data; lt[act_n] = cyc;
      end
      wr_err  = (act_n == err_at);
      act_n++;
      wr_done = 1;
    end
  end

  initial begin
    #(4 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input bit c, input string tag, input int a, input int e);
    total++;
    if (!c) begin bad++; $display("FAIL %s actual=%0h expected=%0h", tag, a, e); end
  endtask

  task automatic px(input logic [7:0] a, input logic [1:0] l, input logic [15:0] d);
    ea[exp_n] = a; el[exp_n] = l; ed[exp_n] = d; exp_n++;
  endtask
  task automatic e_wake(); px(8'h00,0,0); px(8'h00,0,0); px(8'h00,0,0); px(8'hB0,1,16'h17); endtask
  task automatic e_deep(); px(8'hB0,1,0); endtask
  task automatic e_quiet(); px(8'h28,0,0); px(8'hB8,2,16'h8002); px(8'h10,0,0); endtask
  task automatic e_rise(input bit q);
    px(8'hBC,1, q ? 16'h81 : 16'h80); px(8'h3B,1, q ? 16'h22 : 16'h00);
    px(8'hB0,1,16'h16); px(8'hB8,2,16'hFFF9); px(8'h11,0,0);
    px(8'hBA,1,16'h01); px(8'hBB,1,16'h00); px(8'h3A,1,16'h60); px(8'hBF,1,16'h10);
    if (q) px(8'hED,2,16'h00FF); else px(8'hEC,2,16'h01F0);
    px(8'h29,0,0);
  endtask
  task automatic e_route(input logic [1:0] f, input logic [1:0] t);
    if (f == t) return;
    if (f == 0) begin e_wake(); if (t >= 2) e_rise(t == 3); end
    else if (f == 1) begin if (t == 0) e_deep(); else e_rise(t == 3); end
    else begin
      e_quiet();
      if (t == 0) e_deep();
      else if (t >= 2) begin e_deep(); e_wake(); e_rise(t == 3); end
    end
  endtask

  task automatic run_req(input logic [1:0] t);
    int w;
    @(posedge clk); #1; req_valid = 1; req_state = t;
    @(posedge clk); #1; req_valid = 0;
    w = 0;
    while (busy && w < 5000) begin @(posedge clk); #1; w++; end
    chk(w < 5000, "R9 sequence finishes", w, 0);
  endtask

  task automatic cmp_log(input string tag);
    int first = -1;
    for (int i = 0; i < exp_n && i < act_n; i++)
      if (first < 0 && (la[i] != ea[i] || ll[i] != el[i] || ld[i] != ed[i])) first = i;
    if (first < 0) chk(act_n == exp_n, tag, act_n, exp_n);
    else chk(0, tag, {la[first], 6'd0, ll[first], ld[first]}, {ea[first], 6'd0, el[first], ed[first]});
  endtask

  initial begin
    logic [1:0] model;
    repeat (3) @(posedge clk);
    #1;
    chk(cur_state == 0, "R1 reset state", cur_state, 0);
    chk(!busy && !cmd_valid && req_ready, "R1 idle outputs", {busy, cmd_valid, req_ready}, 3'b001);
    chk(!seq_ok && !seq_err, "R1 status low", {seq_ok, seq_err}, 0);
    rst_n = 1;
    model = 0;

    for (int v = 0; v < NV; v++) begin
      exp_n = 0; act_n = 0;
      e_route(model, TO_TAB[v]);
      run_req(TO_TAB[v]);
      chk(act_n == N_TAB[v], "R7 chain length", act_n, N_TAB[v]);
      cmp_log("R2..R7 transcript");
      chk(cur_state == TO_TAB[v], "R9 state committed", cur_state, TO_TAB[v]);
      chk(seq_ok == 1'b1, "R8/R9 ok pulse", seq_ok, 1);
      if (v == 0)
        for (int i = 0; i < 3; i++)
          chk(lt[i+1] - lt[i] - 1 >= KHZ, "R2 pause spacing", lt[i+1] - lt[i] - 1, KHZ);
      model = TO_TAB[v];
    end

    // R10: error on third command of standby -> normal
    act_n = 0; err_at = 2;
    run_req(2'd2);
    repeat (10) @(posedge clk); #1;
    chk(act_n == 3, "R10 no command after error", act_n, 3);
    chk(seq_err == 1'b1, "R10 error flag", seq_err, 1);
    chk(cur_state == 0, "R10 state kept", cur_state, 0);
    err_at = 999;
    act_n = 0;
    @(posedge clk); #1; req_valid = 1; req_state = 2'd1;
    @(posedge clk); #1; req_valid = 0;
    chk(seq_err == 1'b0, "R10 flag clears on accept", seq_err, 0);
    while (busy) begin @(posedge clk); #1; end
    chk(cur_state == 1, "R10 recovery", cur_state, 1);

    // R11: requests during a run are dropped
    act_n = 0; exp_n = 0; e_route(2'd1, 2'd2);
    @(posedge clk); #1; req_valid = 1; req_state = 2'd2;
    @(posedge clk); #1;
    chk(req_ready == 1'b0, "R11 not ready while busy", req_ready, 0);
    while (busy) begin req_valid = 1; req_state = 2'd0; @(posedge clk); #1; end
    req_valid = 0;
    repeat (4) @(posedge clk); #1;
    cmp_log("R11 transcript unchanged");
    chk(cur_state == 2 && !busy, "R11 final state", cur_state, 2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule